// File: doc/BRIEF.md
# Wake-on-Hit Ramp-Compare Converter Controller

This block runs one channel of a ramp-and-compare converter built from general-purpose I/O. While the channel sleeps, the ramp-drive pin is not driven and nothing moves. When a detector hit is flagged, the channel wakes on the next clock edge. It then drives a square wave, one clock per level, that charges and discharges an external capacitor. Each clock period is one ramp half: rising while the pin is high, falling while it is low.

A time-to-digital converter reports the fine time of each comparator transition. The block turns every completed ramp half into one signed sample. The fine code is used as-is on rising halves and inverted on falling halves, so a higher input always maps to a higher code. A half with no comparator transition gives an overflow-flagged sample. Each sample carries a direction tag and a sequence index, so four phase-shifted channels can be interleaved downstream. The channel stays awake for a programmable number of ramp halves after the last hit, then parks the pin low and releases it.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While asleep, `ramp_oe` and `ramp_out` are 0, no sample is produced, and `tdc_valid` and `tdc_fine` have no effect.
- R2: While awake, `ramp_out` inverts on every clock edge, and the first half after a wake is rising (`ramp_out`=1).
- R3: Every completed ramp half produces exactly one sample, with `smp_valid` high for the one cycle after the edge that ends the half.
- R4: A `hit` seen at an edge while asleep or parking sets `ramp_oe`=1 and `ramp_out`=1 from that same edge.
- R5: For a rising half (`ramp_out`=1), the sample code equals the `tdc_fine` presented during that half, and `smp_fall`=0.
- R6: For a falling half (`ramp_out`=0), the sample code is 2^FINE_W-1 minus `tdc_fine`, and `smp_fall`=1.
- R7: If `tdc_valid` is low throughout a half, that half's sample has `smp_ovf`=1 and code 0. Otherwise `smp_ovf`=0.
- R8: After the edge that sees the last hit, the channel completes exactly `hold_len` further ramp halves. A value of 0 counts as 1. A hit seen at the end of a half restarts the count.
- R9: After the final half, `ramp_out` is 0 with `ramp_oe` still 1 for one cycle. Then `ramp_oe` drops to 0.
- R10: `smp_seq` is the index of the half since the wake, counting from 0. It is not reset by a hit while awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, one ramp half per period |
| rst_n | input | 1 | Active-low synchronous reset |
| hit | input | 1 | Detector hit flag |
| hold_len | input | HOLD_W | Ramp halves to stay awake after the last hit |
| tdc_valid | input | 1 | A comparator transition was timed in the current half |
| tdc_fine | input | FINE_W | Fine crossing time of that transition |
| ramp_out | output | 1 | Ramp-drive level |
| ramp_oe | output | 1 | Ramp-drive output enable |
| smp_valid | output | 1 | Sample strobe |
| smp_code | output | FINE_W | Sample code |
| smp_fall | output | 1 | 1 when the sample came from a falling half |
| smp_ovf | output | 1 | No crossing was seen in the half |
| smp_seq | output | SEQ_W | Index of the half since the wake |

## Verification
On every cycle, the assertions check that the pin stays quiet while asleep, that a hit wakes the pin at once, and that the level toggles while awake. They also check that each awake cycle yields a sample whose direction tag and overflow flag match the previous half, and that the park cycle holds the pin low with the enable still set. Only the scripted scenarios show the actual code values, including the inversion on falling halves. The same holds for the exact number of halves before timeout, the restart of the window by a mid-burst hit, the treatment of a zero hold length, and the continuity of the sequence index across a restart.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int FINE_W = 8,
  parameter int HOLD_W = 8,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              tdc_valid,
  input  logic [FINE_W-1:0] tdc_fine,
  output logic              ramp_out,
  output logic              ramp_oe,
  output logic              smp_valid,
  output logic [FINE_W-1:0] smp_code,
  output logic              smp_fall,
  output logic              smp_ovf,
  output logic [SEQ_W-1:0]  smp_seq
);

  typedef enum logic [1:0] {S_SLEEP, S_AWAKE, S_PARK} st_t;

  localparam logic [HOLD_W-1:0] ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

  st_t               st;
  logic [HOLD_W-1:0] rem;
  logic [SEQ_W-1:0]  seq;

  wire [HOLD_W-1:0] reload   = (hold_len == '0) ? ONE : hold_len;
  wire              park_now = (st == S_AWAKE) && !hit && (rem == ONE);
  wire [FINE_W-1:0] code_now = !tdc_valid ? '0 : (ramp_out ? tdc_fine : ~tdc_fine);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_SLEEP;
      ramp_out  <= 1'b0;
      ramp_oe   <= 1'b0;
      rem       <= '0;
      seq       <= '0;
      smp_valid <= 1'b0;
      smp_code  <= '0;
      smp_fall  <= 1'b0;
      smp_ovf   <= 1'b0;
      smp_seq   <= '0;
    end else begin
      smp_valid <= 1'b0;
      case (st)
        S_SLEEP, S_PARK: begin
          if (hit) begin
            st       <= S_AWAKE;
            ramp_oe  <= 1'b1;
            ramp_out <= 1'b1;
            rem      <= reload;
            seq      <= '0;
          end else if (st == S_PARK) begin
            st      <= S_SLEEP;
            ramp_oe <= 1'b0;
          end
        end
        S_AWAKE: begin
          smp_valid <= 1'b1;
          smp_fall  <= !ramp_out;
          smp_ovf   <= !tdc_valid;
          smp_code  <= code_now;
          smp_seq   <= seq;
          seq       <= seq + 1'b1;
          rem       <= hit ? reload : rem - ONE;
          if (park_now) begin
            st       <= S_PARK;
            ramp_out <= 1'b0;
          end else begin
            ramp_out <= !ramp_out;
          end
        end
        default: st <= S_SLEEP;
      endcase
    end
  end

  AST_QUIET_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && !hit) |=> (!ramp_oe && !ramp_out && !smp_valid)); // R1
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AWAKE && !park_now) |=> (ramp_out != $past(ramp_out))); // R2
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AWAKE) |=> smp_valid); // R3
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_AWAKE && hit) |=> (ramp_oe && ramp_out)); // R4
  AST_DIR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AWAKE) |=> (smp_fall == !$past(ramp_out))); // R6
  AST_NO_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AWAKE) |=> (smp_ovf == !$past(tdc_valid))); // R7
  AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PARK) |-> (ramp_oe && !ramp_out)); // R9

endmodule

// File: tb/sim_ramp_adc_ctrl.sv
module sim_ramp_adc_ctrl;
  localparam int CLK_PERIOD = 4;

  typedef struct {
    logic [7:0] code;
    logic       fall;
    logic       ovf;
    logic [7:0] seq;
  } exp_t;

  logic clk = 0, rst_n = 0, hit = 0, tdc_valid = 0;
  logic [7:0] hold_len = 8'd5, tdc_fine = '0;
  logic ramp_out, ramp_oe, smp_valid, smp_fall, smp_ovf;
  logic [7:0] smp_code, smp_seq;

  int checks = 0, errors = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hit(hit), .hold_len(hold_len),
    .tdc_valid(tdc_valid), .tdc_fine(tdc_fine),
    .ramp_out(ramp_out), .ramp_oe(ramp_oe), .smp_valid(smp_valid),
    .smp_code(smp_code), .smp_fall(smp_fall), .smp_ovf(smp_ovf), .smp_seq(smp_seq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops one expected sample per strobe
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      if (q.size() == 0) chk("R3 unexpected sample", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R5/R6 code", smp_code, e.code);
        chk("R6 fall tag", smp_fall, e.fall);
        chk("R7 ovf flag", smp_ovf, e.ovf);
        chk("R10 seq", smp_seq, e.seq);
      end
    end
  end

  task automatic wake();
    hit = 1;
    @(negedge clk);
  endtask

  // drive one ramp half and push its expected sample
  task automatic half(input int i, input bit tv, input logic [7:0] f, input bit h);
    exp_t e;
    chk("R2/R4 drive level", ramp_out, (i % 2 == 0));
    chk("R2/R4 drive enable", ramp_oe, 1);
    hit = h; tdc_valid = tv; tdc_fine = f;
    e.fall = (i % 2 == 1);
    e.ovf  = !tv;
    e.code = !tv ? 8'd0 : (e.fall ? 8'd255 - f : f);
    e.seq  = i[7:0];
    q.push_back(e);
    @(negedge clk);
    hit = 0;
  endtask

  task automatic park_and_sleep();
    tdc_valid = 0;
    chk("R9 park level", ramp_out, 0);
    chk("R9 park enable", ramp_oe, 1);
    @(negedge clk);
    chk("R9 released enable", ramp_oe, 0);
    chk("R8 asleep level", ramp_out, 0);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset enable", ramp_oe, 0);
    chk("R1 reset level", ramp_out, 0);
    chk("R1 reset strobe", smp_valid, 0);
    for (int k = 0; k < 6; k++) begin
      tdc_valid = k[0]; tdc_fine = 8'(k * 37);
      @(negedge clk);
      chk("R1 quiet enable", ramp_oe, 0);
      chk("R1 quiet level", ramp_out, 0);
      chk("R1 no sample", smp_valid, 0);
    end

    // burst 1: hold 5, mixed crossings and a missing one
    hold_len = 8'd5;
    wake();
    half(0, 1, 8'h10, 0);
    half(1, 1, 8'h10, 0);
    half(2, 0, 8'h77, 0);
    half(3, 1, 8'h00, 0);
    half(4, 1, 8'hFF, 0);
    park_and_sleep();
    repeat (3) @(negedge clk);

    // burst 2: hold 4, retrigger at end of half 2 -> 3 + 4 = 7 halves
    hold_len = 8'd4;
    wake();
    for (int i = 0; i < 7; i++) half(i, 1, 8'(20 * i + 3), (i == 2));
    park_and_sleep();
    repeat (2) @(negedge clk);

    // burst 3: hold 0 counts as one half
    hold_len = 8'd0;
    wake();
    half(0, 1, 8'hA5, 0);
    park_and_sleep();
    repeat (4) @(negedge clk);
    chk("R3 all samples seen", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule